// File: doc/BRIEF.md
# Doorbell Interrupt Requester

This block is the interrupt-requesting side of a slave board on a parallel backplane bus with seven prioritised request lines. A remote agent sends a 16-bit doorbell word as a one-cycle strobe. Each word ORs its source bits into a latched status word and raises a single doorbell flag. Software sets the request level, the 8-bit status/ID vector, the release mode and two enables through a small register window.

While the request condition holds, the block drives exactly one request line. The line is picked by the programmed level. When the bus master runs an acknowledge cycle at that level, the block answers with its vector. Otherwise it passes the acknowledge down the daisy chain. In release-on-register-access mode the flag stays set until software clears it. In release-on-acknowledge mode a successful acknowledge clears it.

Top module: `dbirq_top`

## Requirements
- R1: After reset, every register reads 0x00000000, no request line is driven, and neither acknowledge output is asserted.
- R2: The configuration register sits at offset 0x08. Bits 7:0 hold the vector, bits 10:8 the request level, bit 11 the global enable and bit 12 the release mode (0 = release on register access, 1 = release on acknowledge). All 13 bits read back as written, and bits 31:13 read 0.
- R3: The doorbell register sits at offset 0x10 and is read-only. A doorbell strobe ORs bits 15:1 of its word into the latched bits and sets the doorbell flag. Bit 0 of the word is ignored, and bits 31:16 and bit 0 read 0.
- R4: The control register at offset 0x0C acts on write. A 1 in bit 0 enables the doorbell interrupt. A 1 in bit 16 disables it, and disable wins when both are set. A 1 in bit 20 clears the flag and the latched bits. A read returns the enable in bit 0, the flag in bit 20, the internal request (flag AND doorbell enable) in bit 26, and the bus request in bit 27.
- R5: Request line irq_o[L-1] is high exactly when the global enable, the doorbell enable and the flag are all set and the level L is nonzero. At most one line is high, and level 0 drives none.
- R6: An acknowledge strobe whose level equals the programmed level while the bus request is pending gives iack_ack_o high with the vector on iack_vector_o in the next cycle. Any other acknowledge gives iack_pass_o high in the next cycle instead.
- R7: In release-on-register-access mode, an answered acknowledge leaves the flag, the latched bits and the request unchanged.
- R8: In release-on-acknowledge mode, an answered acknowledge clears the flag and the latched bits, which drops the request.
- R9: When a doorbell strobe coincides with a clear, the doorbell wins. The flag stays set and the latched bits equal the new word's bits only.
- R10: Writes to offsets other than 0x08 and 0x0C change no state, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| db_valid_i | input | 1 | Doorbell word strobe |
| db_value_i | input | 16 | Doorbell word |
| irq_o | output | 7 | Request lines, bit k is level k+1, active high |
| iack_valid_i | input | 1 | Acknowledge cycle strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| iack_ack_o | output | 1 | Acknowledge answered by this block |
| iack_vector_o | output | 8 | Vector returned when answered, else 0 |
| iack_pass_o | output | 1 | Acknowledge passed down the daisy chain |

## Verification
Register writes, doorbell strobes and clears take effect at the clock edge that samples them. Read data and the request lines are combinational from that state, so they are due one edge after the stimulus. Acknowledge answers and pass-ons are registered, so they appear in the cycle after the acknowledge strobe. A release on acknowledge takes effect at that same edge. The bench drives inputs on the falling edge and samples on the next falling edge, which places each observation after exactly one rising edge.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned DB_W    = 16;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;

  // configuration register layout
  localparam int unsigned CFG_VEC_LSB = 0;
  localparam int unsigned CFG_LVL_LSB = CFG_VEC_LSB + VEC_W;
  localparam int unsigned CFG_GEN_BIT = CFG_LVL_LSB + LVL_W;
  localparam int unsigned CFG_REL_BIT = CFG_GEN_BIT + 1;
  localparam int unsigned CFG_USED    = CFG_REL_BIT + 1;

  // control register bits
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_DIS_BIT  = 16;
  localparam int unsigned CTL_CLR_BIT  = 20;
  localparam int unsigned CTL_FLAG_BIT = 20;
  localparam int unsigned CTL_INT_BIT  = 26;
  localparam int unsigned CTL_BUS_BIT  = 27;

  localparam logic [7:0] OFS_CFG  = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h0C;
  localparam logic [7:0] OFS_DB   = 8'h10;

  typedef struct packed {
    logic             rel_on_ack;
    logic             glb_en;
    logic [LVL_W-1:0] level;
    logic [VEC_W-1:0] vector;
  } cfg_t;
endpackage

// File: rtl/dbirq_cfg_regs.sv
module dbirq_cfg_regs
  import dbirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cfg_i,
  input  logic             wr_ctrl_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic             db_en_o,
  output logic             sw_clr_o
);
  cfg_t cfg_q;
  logic db_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      db_en_q <= 1'b0;
    end else begin
      if (wr_cfg_i) cfg_q <= cfg_t'(wdata_i[CFG_USED-1:0]);
      if (wr_ctrl_i) begin
        if (wdata_i[CTL_DIS_BIT])     db_en_q <= 1'b0;  // disable wins
        else if (wdata_i[CTL_EN_BIT]) db_en_q <= 1'b1;
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign db_en_o  = db_en_q;
  assign sw_clr_o = wr_ctrl_i && wdata_i[CTL_CLR_BIT];

  p_dis_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && wdata_i[CTL_DIS_BIT]) |=> !db_en_o);
endmodule

// File: rtl/dbirq_db_latch.sv
module dbirq_db_latch
  import dbirq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            db_valid_i,
  input  logic [DB_W-1:0] db_value_i,
  input  logic            sw_clr_i,
  input  logic            ack_rel_i,
  output logic            flag_o,
  output logic [DB_W-1:0] bits_o
);
  logic            flag_q;
  logic [DB_W-1:0] bits_q;
  logic            clr;
  logic [DB_W-1:0] new_bits;

  assign clr      = sw_clr_i || ack_rel_i;
  assign new_bits = {db_value_i[DB_W-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      bits_q <= '0;
    end else if (db_valid_i) begin
      flag_q <= 1'b1;
      bits_q <= (clr ? '0 : bits_q) | new_bits;
    end else if (clr) begin
      flag_q <= 1'b0;
      bits_q <= '0;
    end
  end

  assign flag_o = flag_q;
  assign bits_o = bits_q;

  p_db_sets_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_i |=> flag_o);
  p_bit0_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bits_o[0]);
  p_clr_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr_i && !db_valid_i) |=> (!flag_o && bits_o == '0));
endmodule

// File: rtl/dbirq_iack.sv
module dbirq_iack
  import dbirq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  input  logic             db_en_i,
  input  logic             flag_i,
  input  logic             iack_valid_i,
  input  logic [LVL_W-1:0] iack_level_i,
  output logic             int_req_o,
  output logic             bus_req_o,
  output logic [NUM_LVL-1:0] irq_o,
  output logic             ack_rel_o,
  output logic             ack_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             pass_o
);
  logic             hit;
  logic             ack_q, pass_q;
  logic [VEC_W-1:0] vec_q;

  assign int_req_o = flag_i && db_en_i;
  assign bus_req_o = int_req_o && cfg_i.glb_en && (cfg_i.level != '0);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_line
    assign irq_o[k] = bus_req_o && (cfg_i.level == LVL_W'(k + 1));
  end

  assign hit       = iack_valid_i && bus_req_o && (iack_level_i == cfg_i.level);
  assign ack_rel_o = hit && cfg_i.rel_on_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      pass_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      ack_q  <= hit;
      pass_q <= iack_valid_i && !hit;
      vec_q  <= hit ? cfg_i.vector : '0;
    end
  end

  assign ack_o    = ack_q;
  assign pass_o   = pass_q;
  assign vector_o = vec_q;

  p_one_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  p_lvl0_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.level == '0) |-> (irq_o == '0));
  p_ack_xor_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && pass_o));
  p_iack_answered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_valid_i |=> (ack_o || pass_o));
endmodule

// File: rtl/dbirq_top.sv
module dbirq_top
  import dbirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic                db_valid_i,
  input  logic [DB_W-1:0]     db_value_i,
  output logic [NUM_LVL-1:0]  irq_o,
  input  logic                iack_valid_i,
  input  logic [LVL_W-1:0]    iack_level_i,
  output logic                iack_ack_o,
  output logic [VEC_W-1:0]    iack_vector_o,
  output logic                iack_pass_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DB   = ADDR_W'(OFS_DB);

  cfg_t            cfg;
  logic            db_en, sw_clr, flag, ack_rel, int_req, bus_req;
  logic [DB_W-1:0] db_bits;
  logic            wr_cfg, wr_ctrl;

  assign wr_cfg  = reg_we_i && (reg_addr_i == A_CFG);
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);

  dbirq_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cfg_i  (wr_cfg),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (reg_wdata_i),
    .cfg_o     (cfg),
    .db_en_o   (db_en),
    .sw_clr_o  (sw_clr)
  );

  dbirq_db_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .db_valid_i (db_valid_i),
    .db_value_i (db_value_i),
    .sw_clr_i   (sw_clr),
    .ack_rel_i  (ack_rel),
    .flag_o     (flag),
    .bits_o     (db_bits)
  );

  dbirq_iack u_iack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .db_en_i      (db_en),
    .flag_i       (flag),
    .iack_valid_i (iack_valid_i),
    .iack_level_i (iack_level_i),
    .int_req_o    (int_req),
    .bus_req_o    (bus_req),
    .irq_o        (irq_o),
    .ack_rel_o    (ack_rel),
    .ack_o        (iack_ack_o),
    .vector_o     (iack_vector_o),
    .pass_o       (iack_pass_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CFG:  reg_rdata_o[CFG_USED-1:0] = cfg;
      A_CTRL: begin
        reg_rdata_o[CTL_EN_BIT]   = db_en;
        reg_rdata_o[CTL_FLAG_BIT] = flag;
        reg_rdata_o[CTL_INT_BIT]  = int_req;
        reg_rdata_o[CTL_BUS_BIT]  = bus_req;
      end
      A_DB:   reg_rdata_o[DB_W-1:0] = db_bits;
      default: reg_rdata_o = '0;
    endcase
  end

  p_rora_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_valid_i && bus_req && iack_level_i == cfg.level && !cfg.rel_on_ack && !sw_clr)
    |=> flag);
  p_roak_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rel && !db_valid_i) |=> (!flag && irq_o == '0));
  p_db_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_i && (sw_clr || ack_rel)) |=> (flag && db_bits == {$past(db_value_i[DB_W-1:1]), 1'b0}));
endmodule

// File: tb/dbirq_top_tb.sv
module dbirq_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        db_valid_i = 1'b0;
  logic [15:0] db_value_i = '0;
  logic [6:0]  irq_o;
  logic        iack_valid_i = 1'b0;
  logic [2:0]  iack_level_i = '0;
  logic        iack_ack_o;
  logic [7:0]  iack_vector_o;
  logic        iack_pass_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbirq_top u_dut (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .db_valid_i, .db_value_i, .irq_o, .iack_valid_i, .iack_level_i,
    .iack_ack_o, .iack_vector_o, .iack_pass_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic bell(logic [15:0] v, bit with_clr);
    db_value_i = v; db_valid_i = 1'b1;
    if (with_clr) begin
      reg_addr_i = 8'h0C; reg_wdata_i = 32'h0010_0000; reg_we_i = 1'b1;
    end
    @(negedge clk_i);
    db_valid_i = 1'b0; db_value_i = '0; reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic iack(string req, logic [2:0] lvl, bit exp_ack, logic [7:0] exp_vec);
    iack_level_i = lvl; iack_valid_i = 1'b1;
    @(negedge clk_i);
    iack_valid_i = 1'b0;
    chk(req, {23'b0, iack_ack_o, iack_vector_o}, {23'b0, exp_ack, exp_ack ? exp_vec : 8'h00});
    chk(req, {31'b0, iack_pass_o}, {31'b0, !exp_ack});
  endtask

  task automatic t_reset();
    rd_chk("R1", 8'h08, 0); rd_chk("R1", 8'h0C, 0); rd_chk("R1", 8'h10, 0);
    chk("R1", {25'b0, irq_o}, 0);
    chk("R1", {30'b0, iack_ack_o, iack_pass_o}, 0);
  endtask

  task automatic t_cfg_rw();
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h08, 32'h0000_1FFF);
    wr(8'h08, 32'h0000_0000);
    rd_chk("R2", 8'h08, 0);
  endtask

  task automatic t_unmapped();
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R10", 8'h08, 0); rd_chk("R10", 8'h0C, 0);
    rd_chk("R10", 8'h10, 0); rd_chk("R10", 8'h14, 0);
  endtask

  task automatic t_doorbell();
    bell(16'h0003, 1'b0);
    rd_chk("R3", 8'h10, 32'h0000_0002);
    rd_chk("R3", 8'h0C, 32'h0010_0000);
    bell(16'h8000, 1'b0);
    rd_chk("R3", 8'h10, 32'h0000_8002);
  endtask

  task automatic t_enable_gate();
    wr(8'h0C, 32'h0000_0001);
    rd_chk("R4", 8'h0C, 32'h0410_0001);
    chk("R5", {25'b0, irq_o}, 0);
    wr(8'h08, 32'h0000_0BA5);
    chk("R5", {25'b0, irq_o}, 32'h04);
    rd_chk("R4", 8'h0C, 32'h0C10_0001);
  endtask

  task automatic t_rora();
    iack("R6", 3'd2, 1'b0, 8'h00);
    iack("R6", 3'd3, 1'b1, 8'hA5);
    chk("R7", {25'b0, irq_o}, 32'h04);
    rd_chk("R7", 8'h10, 32'h0000_8002);
    wr(8'h0C, 32'h0010_0000);
    rd_chk("R4", 8'h10, 0);
    rd_chk("R4", 8'h0C, 32'h0000_0001);
    chk("R4", {25'b0, irq_o}, 0);
  endtask

  task automatic t_level0();
    wr(8'h08, 32'h0000_08A5);
    bell(16'h0010, 1'b0);
    chk("R5", {25'b0, irq_o}, 0);
    iack("R5", 3'd0, 1'b0, 8'h00);
  endtask

  task automatic t_roak();
    wr(8'h08, 32'h0000_1E3C);
    chk("R5", {25'b0, irq_o}, 32'h20);
    iack("R8", 3'd6, 1'b1, 8'h3C);
    chk("R8", {25'b0, irq_o}, 0);
    rd_chk("R8", 8'h10, 0);
    rd_chk("R8", 8'h0C, 32'h0000_0001);
  endtask

  task automatic t_disable();
    bell(16'h0002, 1'b0);
    chk("R5", {25'b0, irq_o}, 32'h20);
    wr(8'h0C, 32'h0001_0001);
    chk("R4", {25'b0, irq_o}, 0);
    rd_chk("R4", 8'h0C, 32'h0010_0000);
  endtask

  task automatic t_collide();
    bell(16'h0101, 1'b1);
    rd_chk("R9", 8'h10, 32'h0000_0100);
    rd_chk("R9", 8'h0C, 32'h0010_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cfg_rw();
    t_unmapped();
    t_doorbell();
    t_enable_gate();
    t_rora();
    t_level0();
    t_roak();
    t_disable();
    t_collide();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule